// File: doc/BRIEF.md
# Cascadable synchronous binary counter

This block is a four-bit binary up-counter whose state moves only on the rising clock edge. At each edge it does one of four things: it clears, it loads a parallel data word, it steps up by one, or it holds. An active-low load input copies the data word into the count. Two active-high count enables must both be high for the count to step. The first enable only gates counting. The second enable also gates the terminal-count output.

Terminal count is high while the count is at its maximum (15) and the second enable is high. Wiring one stage's terminal count into the second enable of the next stage, with the first enables shared, makes a chain that counts as one wide binary counter. Each upper stage steps exactly once per wrap of the stage below it.

An elaboration-time parameter selects the clear style. In asynchronous style the clear acts at once. In synchronous style it takes effect at the next rising edge. The clear is active-low in both styles.

Top module: `chain_counter4`

## Requirements
- R1: With the load input high and at least one of the two count enables low, the count keeps its value across a rising edge.
- R2: When the load input is low at a rising edge (clear inactive), the count takes the data word, whatever the levels of both count enables.
- R3: When load is high and both enables are high at a rising edge, the count rises by one. From 15 it wraps to 0, with no flag.
- R4: With the clear style parameter at CLR_ASYNC (value 0), a low clear drives the count to 0 at once, without a clock edge, overriding load and both enables.
- R5: With the clear style parameter at CLR_SYNC (value 1), a low clear sets the count to 0 at the next rising edge, overriding load and both enables. Until that edge the count keeps its old value.
- R6: Terminal count is 1 exactly when the count is 15 and the second (trickle) enable is 1. The first (parallel) enable has no effect on it.
- R7: In a chain where each stage's terminal count drives the next stage's trickle enable and all stages share the parallel enable, load and clear, the chain holds the same value as one wide binary counter. The upper stage advances once for each wrap of the lower stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per parameter |
| load_n | input | 1 | Active-low parallel load of `din` |
| en_par | input | 1 | Count enable that gates counting only |
| en_trk | input | 1 | Count enable that gates counting and terminal count |
| din | input | 4 | Parallel data word |
| count | output | 4 | Registered count value |
| tc | output | 1 | Terminal count (count at 15 and `en_trk` high) |

## Verification
The clocked assertions on load, stepping and holding assume that the control inputs are steady over a whole clock period. They also assume that the clear has been held low at least once before any of them is relied on. The stimulus meets both conditions: every input changes only on the falling clock edge, and the run opens with the clear held low. The asynchronous-clear check assumes that the clear falls between edges and is still low at the next rising edge. The bench lowers the clear on a falling edge and holds it low for the rest of the period. It also compares the two styles in the middle of that period, which is the one point where they differ.

// File: rtl/cnt4_pkg.sv
package cnt4_pkg;

    // Clear behaviour selected at elaboration time.
    typedef enum logic [0:0] {
        CLR_ASYNC = 1'b0,
        CLR_SYNC  = 1'b1
    } clr_style_e;

    // Action taken at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2,
        OP_ZERO = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt4_decode.sv
module cnt4_decode
    import cnt4_pkg::*;
#(
    parameter clr_style_e CLR_STYLE = CLR_ASYNC
) (
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cnt_op_e op
);

    // Priority: clear (sync style only), then load, then step, then hold.
    always_comb begin
        op = OP_HOLD;
        if (CLR_STYLE == CLR_SYNC && !clr_n) begin
            op = OP_ZERO;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_trk) begin
            op = OP_STEP;
        end
    end

endmodule

// File: rtl/cnt4_state.sv
module cnt4_state
    import cnt4_pkg::*;
#(
    parameter int         WIDTH     = 4,
    parameter clr_style_e CLR_STYLE = CLR_ASYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_LOAD: st_d.value = din;
            OP_STEP: st_d.value = st_q.value + ONE;
            OP_ZERO: st_d.value = '0;
            default: st_d.value = st_q.value;
        endcase
    end

    generate
        if (CLR_STYLE == CLR_ASYNC) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // R4
            async_clr_chk: assert property (@(posedge clk)
                !clr_n |-> (count == '0))
                else $error("async clear did not hold count at zero");
        end else begin : g_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            // R5
            sync_clr_chk: assert property (@(posedge clk)
                !clr_n |=> (count == '0))
                else $error("sync clear did not zero count at edge");
        end
    endgenerate

    assign count = st_q.value;

    // R2
    load_takes_din_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> (count == $past(din)))
        else $error("load did not capture data");

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_STEP) |=> (count == WIDTH'($past(count) + ONE)))
        else $error("count did not step by one");

    // R1
    hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_HOLD) |=> $stable(count))
        else $error("count changed while holding");

endmodule

// File: rtl/cnt4_tc.sv
module cnt4_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             en_trk,
    output logic             tc
);

    always_comb begin
        tc = en_trk & (&count);
    end

endmodule

// File: rtl/chain_counter4.sv
module chain_counter4
    import cnt4_pkg::*;
#(
    parameter int         WIDTH     = 4,
    parameter clr_style_e CLR_STYLE = CLR_ASYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             tc
);

    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    cnt_op_e op;

    cnt4_decode #(.CLR_STYLE(CLR_STYLE)) u_decode (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    cnt4_state #(.WIDTH(WIDTH), .CLR_STYLE(CLR_STYLE)) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .count (count)
    );

    cnt4_tc #(.WIDTH(WIDTH)) u_tc (
        .count  (count),
        .en_trk (en_trk),
        .tc     (tc)
    );

    // R6
    tc_needs_trk_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !en_trk |-> !tc)
        else $error("terminal count high with trickle enable low");

    // R6
    tc_at_top_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (en_trk && count == TOP_VAL) |-> tc)
        else $error("terminal count missing at top value");

endmodule

// File: tb/tb_chain_counter4.sv
`timescale 1ns/1ps
module tb_chain_counter4;
    import cnt4_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       clr_n  = 1'b1;
    logic       load_n = 1'b1;
    logic       en_par = 1'b0;
    logic       en_trk = 1'b0;
    logic [7:0] din8   = 8'h00;

    logic [3:0] a_lo, a_hi, s_lo, s_hi;
    logic       a_tclo, a_tchi, s_tclo, s_tchi;

    // Asynchronous-clear chain: dut is the low stage.
    chain_counter4 #(.CLR_STYLE(CLR_ASYNC)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din8[3:0]), .count(a_lo), .tc(a_tclo));
    chain_counter4 #(.CLR_STYLE(CLR_ASYNC)) dut_a_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(a_tclo), .din(din8[7:4]), .count(a_hi), .tc(a_tchi));

    // Synchronous-clear chain.
    chain_counter4 #(.CLR_STYLE(CLR_SYNC)) dut_s_lo (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din8[3:0]), .count(s_lo), .tc(s_tclo));
    chain_counter4 #(.CLR_STYLE(CLR_SYNC)) dut_s_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(s_tclo), .din(din8[7:4]), .count(s_hi), .tc(s_tchi));

    typedef struct packed {
        logic [7:0] cnt;
        logic       tclo;
        logic       tchi;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    int         checks = 0;
    int         errors = 0;
    logic [7:0] ref_cnt = 8'h00;
    bit         ref_valid = 1'b0;
    bit         done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: apply inputs on the falling edge, predict the result of the next rising edge.
    task automatic step(input logic c, input logic l, input logic p, input logic t,
                        input logic [7:0] d, input string tag);
        logic [7:0] prev;
        exp_t       e;
        @(negedge clk);
        clr_n  = c;
        load_n = l;
        en_par = p;
        en_trk = t;
        din8   = d;
        prev   = ref_cnt;
        if (!c)          ref_cnt = 8'h00;
        else if (!l)     ref_cnt = d;
        else if (p && t) ref_cnt = ref_cnt + 8'h01;
        e.cnt  = ref_cnt;
        e.tclo = t && (ref_cnt[3:0] == 4'hF);
        e.tchi = e.tclo && (ref_cnt[7:4] == 4'hF);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (!c && ref_valid) begin
            #1;
            // R4: asynchronous style is already zero mid-cycle
            chk("R4", "async count mid-cycle", {a_hi, a_lo}, 8'h00);
            // R5: synchronous style keeps its value until the edge
            chk("R5", "sync count mid-cycle", {s_hi, s_lo}, prev);
        end
        if (!c) ref_valid = 1'b1;
    endtask

    // Monitor: compare just after each rising edge.
    exp_t  mon_e;
    string mon_tag;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                mon_e   = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                chk(mon_tag, "async chain count", {a_hi, a_lo}, mon_e.cnt);
                chk(mon_tag, "sync chain count",  {s_hi, s_lo}, mon_e.cnt);
                chk(mon_tag, "low stage tc",  {7'd0, a_tclo}, {7'd0, mon_e.tclo});
                chk(mon_tag, "high stage tc", {7'd0, a_tchi}, {7'd0, mon_e.tchi});
                chk(mon_tag, "sync high tc",  {7'd0, s_tchi}, {7'd0, mon_e.tchi});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        #1 clr_n = 1'b0;
        // reset state, both styles (R4, R5)
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R5");
        // long count through the 255 -> 0 wrap of the chain (R3, R7)
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R7");
        // load overrides enables low and high (R2)
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0E, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, "R2");
        // hold with one enable low (R1)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 8'h77, "R1");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 8'h77, "R1");
        // terminal count independent of parallel enable (R6)
        step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6");
        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R6");
        // single wrap of low stage advances high stage once (R7, R3)
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h4E, "R7");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3");
        // clear overrides a pending load and both enables (R4, R5)
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'hC3, "R2");
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R4");
        // mixed pattern
        for (int i = 0; i < 600; i++) begin
            logic c, l, p, t;
            string tg;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = (lfsr[3:0] != 4'h0);
            l = (lfsr[7:5] != 3'h0);
            p = lfsr[8] | lfsr[9];
            t = lfsr[10] | lfsr[11];
            if (!c)          tg = "R5";
            else if (!l)     tg = "R2";
            else if (p && t) tg = "R3";
            else             tg = "R1";
            step(c, l, p, t, lfsr[15:8] ^ lfsr[7:0], tg);
        end
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule